// File: doc/BRIEF.md
# Boundary-Scan Register Chain

This block is the serial test register that wraps the pins of a small device: two dedicated inputs, two tri-state outputs and two bidirectional pins. It is made of twelve cells. Each cell has a capture/shift flop clocked on the rising test clock. Output-data and output-control cells also have an update latch that loads on the falling test clock. A test access port controller outside the block supplies the serial input and the capture, shift and update strobes. It also supplies a flag that hands the output pins to the test logic.

When the flag is clear, the core drives the pads directly, and a capture takes a snapshot of pins and core signals without disturbing them. When the flag is set, every output pin value and output enable comes from an update latch. The bench can therefore shift in a pattern and apply it to the board. A control cell holding 0 disables its pin, so the pin floats. The cell counts per pin kind are parameters. The cell order is fixed: inputs first, then data/control pairs for the tri-state outputs, then input/data/control triples for the bidirectional pins.

Top module: `bscan_chain`

## Requirements
- R1: The chain holds 12 cells numbered 0 to 11. Cell 0 drives `tdo` and cell 11 receives `tdi`. After a capture, the k-th bit seen on `tdo` (first bit k=0) is cell k.
- R2: On a rising `tck` with `cap_dr` high, the cells load as follows. Cells 0 and 1 take `pin_in[0]` and `pin_in[1]`. Cells 2, 3, 4 and 5 take `core_out[0]`, `core_oe[0]`, `core_out[1]` and `core_oe[1]`. Cells 6, 7 and 8 take `pin_bi[0]`, `core_bo[0]` and `core_boe[0]`. Cells 9, 10 and 11 take the same three signals at index 1. Capture has priority over shift.
- R3: On a rising `tck` with `shf_dr` high and `cap_dr` low, each cell takes the value of the cell one above it, and cell 11 takes `tdi`. With neither strobe high, the shift stages hold their values.
- R4: Update latches load from their shift stages only on a falling `tck` with `upd_dr` high. Shifting or capturing leaves them, and so the pins under test mode, unchanged.
- R5: With `extest` high, the pins are driven from the update latches. `pin_out[k]` and `pin_oe[k]` come from cells 2+2k and 3+2k. `pin_bo[k]` and `pin_boe[k]` come from cells 7+3k and 8+3k.
- R6: A control latch holding 0 drives its enable to 0 under `extest`, so the pin floats. A control latch holding 1 enables the pin.
- R7: With `extest` low, `pin_out`, `pin_oe`, `pin_bo` and `pin_boe` equal `core_out`, `core_oe`, `core_bo` and `core_boe`, whatever the latches hold.
- R8: While `rst_n` is low, all shift stages are 0. Control latches are 1 and data latches are 0, so under `extest` the outputs drive 0 with their enables set.
- R9: `core_in` follows `pin_in` and `core_bi` follows `pin_bi` in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low test reset |
| tdi | input | 1 | Serial data into cell 11 |
| cap_dr | input | 1 | Capture strobe (rising edge) |
| shf_dr | input | 1 | Shift strobe (rising edge) |
| upd_dr | input | 1 | Update strobe (falling edge) |
| extest | input | 1 | Pins driven from the update latches when high |
| core_out | input | 2 | Core data for the tri-state outputs |
| core_oe | input | 2 | Core enables for the tri-state outputs |
| core_bo | input | 2 | Core data for the bidirectional pins |
| core_boe | input | 2 | Core enables for the bidirectional pins |
| pin_in | input | 2 | Values at the dedicated input pins |
| pin_bi | input | 2 | Values seen at the bidirectional pins |
| pin_out | output | 2 | Data to the tri-state output pads |
| pin_oe | output | 2 | Enables to the tri-state output pads (0 = Z) |
| pin_bo | output | 2 | Data to the bidirectional pads |
| pin_boe | output | 2 | Enables to the bidirectional pads (0 = Z) |
| core_in | output | 2 | Dedicated input values returned to the core |
| core_bi | output | 2 | Bidirectional pin values returned to the core |
| tdo | output | 1 | Serial data from cell 0 |

## Verification
The bench unloads a capture with a different value on every source. A swapped or off-by-one cell then shows up as a wrong bit position, and a chain reversed end to end sends out a mirrored word. It shifts a new pattern in under test mode and checks the pins before the update strobe. A latch that is transparent or loads on the wrong edge would change the pins in the middle of a shift. It loads control zeros to check that the pins float. It reads the pins straight after reset to catch a control latch that resets to 0 or a data latch that resets to 1. It also clears the mode flag with unusual latch contents, to catch pins that do not return to the core.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

   // Cell index helpers: inputs first, then data/control pairs for the
   // tri-state outputs, then input/data/control triples for the
   // bidirectional pins.
   function automatic int chain_len(int ni, int nt, int nb);
      return ni + 2 * nt + 3 * nb;
   endfunction

   function automatic int tri_data_idx(int ni, int k);
      return ni + 2 * k;
   endfunction

   function automatic int tri_ctrl_idx(int ni, int k);
      return ni + 2 * k + 1;
   endfunction

   function automatic int bi_in_idx(int ni, int nt, int k);
      return ni + 2 * nt + 3 * k;
   endfunction

   function automatic int bi_data_idx(int ni, int nt, int k);
      return ni + 2 * nt + 3 * k + 1;
   endfunction

   function automatic int bi_ctrl_idx(int ni, int nt, int k);
      return ni + 2 * nt + 3 * k + 2;
   endfunction

   // Safe values loaded into the update latches by reset
   localparam logic SAFE_DATA = 1'b0;
   localparam logic SAFE_CTRL = 1'b1;

endpackage

// File: rtl/bsc_shift_stage.sv
module bsc_shift_stage (
   input  logic tck,
   input  logic rst_n,
   input  logic cap,
   input  logic shf,
   input  logic cap_val,
   input  logic ser_in,
   output logic q
);

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)
         q <= 1'b0;
      else if (cap)
         q <= cap_val;
      else if (shf)
         q <= ser_in;
   end

endmodule

// File: rtl/bsc_upd_latch.sv
module bsc_upd_latch #(
   parameter logic SAFE = 1'b0
) (
   input  logic tck,
   input  logic rst_n,
   input  logic upd,
   input  logic d,
   output logic q
);

   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n)
         q <= SAFE;
      else if (upd)
         q <= d;
   end

endmodule

// File: rtl/bsc_pin_drv.sv
module bsc_pin_drv (
   input  logic extest,
   input  logic core_d,
   input  logic core_en,
   input  logic lat_d,
   input  logic lat_en,
   output logic pad_d,
   output logic pad_en
);

   always_comb begin
      if (extest) begin
         pad_d  = lat_d;
         pad_en = lat_en;
      end else begin
         pad_d  = core_d;
         pad_en = core_en;
      end
   end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
   import bscan_pkg::*;
#(
   parameter int N_IN  = 2,
   parameter int N_TRI = 2,
   parameter int N_BI  = 2
) (
   input  logic             tck,
   input  logic             rst_n,
   input  logic             tdi,
   input  logic             cap_dr,
   input  logic             shf_dr,
   input  logic             upd_dr,
   input  logic             extest,
   input  logic [N_TRI-1:0] core_out,
   input  logic [N_TRI-1:0] core_oe,
   input  logic [N_BI-1:0]  core_bo,
   input  logic [N_BI-1:0]  core_boe,
   input  logic [N_IN-1:0]  pin_in,
   input  logic [N_BI-1:0]  pin_bi,
   output logic [N_TRI-1:0] pin_out,
   output logic [N_TRI-1:0] pin_oe,
   output logic [N_BI-1:0]  pin_bo,
   output logic [N_BI-1:0]  pin_boe,
   output logic [N_IN-1:0]  core_in,
   output logic [N_BI-1:0]  core_bi,
   output logic             tdo
);

   localparam int LEN = chain_len(N_IN, N_TRI, N_BI);

   if (N_IN < 1 || N_TRI < 1 || N_BI < 1) begin : g_bad_counts
      $error("bscan_chain: each pin kind needs at least one pin");
   end
   if (LEN > 1024) begin : g_bad_len
      $error("bscan_chain: chain too long");
   end

   logic [LEN-1:0] chain_q;
   logic [LEN-1:0] cap_val;
   logic [LEN-1:0] ser_in;

   // Serial path: cell i takes cell i+1, top cell takes tdi
   assign ser_in = {tdi, chain_q[LEN-1:1]};
   assign tdo    = chain_q[0];

   // Core-side inputs observe the pins without intrusion
   assign core_in = pin_in;
   assign core_bi = pin_bi;

   for (genvar i = 0; i < LEN; i++) begin : g_cell
      bsc_shift_stage u_stage (
         .tck    (tck),
         .rst_n  (rst_n),
         .cap    (cap_dr),
         .shf    (shf_dr),
         .cap_val(cap_val[i]),
         .ser_in (ser_in[i]),
         .q      (chain_q[i])
      );
   end

   for (genvar k = 0; k < N_IN; k++) begin : g_in
      assign cap_val[k] = pin_in[k];
   end

   for (genvar k = 0; k < N_TRI; k++) begin : g_tri
      localparam int DI = tri_data_idx(N_IN, k);
      localparam int CI = tri_ctrl_idx(N_IN, k);
      logic lat_d, lat_en;

      assign cap_val[DI] = core_out[k];
      assign cap_val[CI] = core_oe[k];

      bsc_upd_latch #(.SAFE(SAFE_DATA)) u_dlat (
         .tck(tck), .rst_n(rst_n), .upd(upd_dr), .d(chain_q[DI]), .q(lat_d)
      );
      bsc_upd_latch #(.SAFE(SAFE_CTRL)) u_clat (
         .tck(tck), .rst_n(rst_n), .upd(upd_dr), .d(chain_q[CI]), .q(lat_en)
      );
      bsc_pin_drv u_drv (
         .extest (extest),
         .core_d (core_out[k]),
         .core_en(core_oe[k]),
         .lat_d  (lat_d),
         .lat_en (lat_en),
         .pad_d  (pin_out[k]),
         .pad_en (pin_oe[k])
      );
   end

   for (genvar k = 0; k < N_BI; k++) begin : g_bi
      localparam int II = bi_in_idx(N_IN, N_TRI, k);
      localparam int DI = bi_data_idx(N_IN, N_TRI, k);
      localparam int CI = bi_ctrl_idx(N_IN, N_TRI, k);
      logic lat_d, lat_en;

      assign cap_val[II] = pin_bi[k];
      assign cap_val[DI] = core_bo[k];
      assign cap_val[CI] = core_boe[k];

      bsc_upd_latch #(.SAFE(SAFE_DATA)) u_dlat (
         .tck(tck), .rst_n(rst_n), .upd(upd_dr), .d(chain_q[DI]), .q(lat_d)
      );
      bsc_upd_latch #(.SAFE(SAFE_CTRL)) u_clat (
         .tck(tck), .rst_n(rst_n), .upd(upd_dr), .d(chain_q[CI]), .q(lat_en)
      );
      bsc_pin_drv u_drv (
         .extest (extest),
         .core_d (core_bo[k]),
         .core_en(core_boe[k]),
         .lat_d  (lat_d),
         .lat_en (lat_en),
         .pad_d  (pin_bo[k]),
         .pad_en (pin_boe[k])
      );
   end

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
   parameter int N_IN  = 2,
   parameter int N_TRI = 2,
   parameter int N_BI  = 2,
   parameter int LEN   = 12
) (
   input logic             tck,
   input logic             rst_n,
   input logic             tdi,
   input logic             cap_dr,
   input logic             shf_dr,
   input logic             upd_dr,
   input logic             extest,
   input logic [N_IN-1:0]  pin_in,
   input logic [N_TRI-1:0] pin_out,
   input logic [N_TRI-1:0] pin_oe,
   input logic [N_BI-1:0]  pin_bo,
   input logic [N_BI-1:0]  pin_boe,
   input logic [LEN-1:0]   chain_q,
   input logic             tdo
);

   // R2: the first cell observes the first dedicated input
   a_r2_capture_in: assert property (@(posedge tck) disable iff (!rst_n)
      cap_dr |=> chain_q[0] == $past(pin_in[0]));

   // R3: one shift moves cell 1 onto tdo
   a_r3_shift_tdo: assert property (@(posedge tck) disable iff (!rst_n)
      (shf_dr && !cap_dr) |=> tdo == $past(chain_q[1]));

   // R3: tdi enters the top cell
   a_r3_tdi_entry: assert property (@(posedge tck) disable iff (!rst_n)
      (shf_dr && !cap_dr) |=> chain_q[LEN-1] == $past(tdi));

   // R3: no strobe, no movement
   a_r3_hold: assert property (@(posedge tck) disable iff (!rst_n)
      (!shf_dr && !cap_dr) |=> $stable(chain_q));

   // R4: under test mode the pins move only across an update
   a_r4_latch_hold: assert property (@(posedge tck) disable iff (!rst_n)
      (extest && $past(extest) && !upd_dr) |->
         ($stable(pin_out) && $stable(pin_oe) && $stable(pin_bo) && $stable(pin_boe)));

   // R8: safe values while reset is held
   always @(negedge tck) begin
      if (!rst_n && extest) begin
         a_r8_safe_reset: assert (pin_oe == '1 && pin_boe == '1 &&
                                  pin_out == '0 && pin_bo == '0 && tdo == 1'b0);
      end
   end

endmodule

bind bscan_chain bscan_chain_chk #(
   .N_IN (N_IN),
   .N_TRI(N_TRI),
   .N_BI (N_BI),
   .LEN  (LEN)
) u_chk (
   .tck    (tck),
   .rst_n  (rst_n),
   .tdi    (tdi),
   .cap_dr (cap_dr),
   .shf_dr (shf_dr),
   .upd_dr (upd_dr),
   .extest (extest),
   .pin_in (pin_in),
   .pin_out(pin_out),
   .pin_oe (pin_oe),
   .pin_bo (pin_bo),
   .pin_boe(pin_boe),
   .chain_q(chain_q),
   .tdo    (tdo)
);

// File: tb/bscan_chain_test.sv
module bscan_chain_test;

   logic       tck = 1'b0;
   logic       rst_n = 1'b1;
   logic       tdi = 1'b0, cap_dr = 1'b0, shf_dr = 1'b0, upd_dr = 1'b0;
   logic       extest = 1'b1;
   logic [1:0] core_out = '0, core_oe = '0, core_bo = '0, core_boe = '0;
   logic [1:0] pin_in = '0, pin_bi = '0;
   logic [1:0] pin_out, pin_oe, pin_bo, pin_boe, core_in, core_bi;
   logic       tdo;

   int n_run = 0;
   int n_fail = 0;

   always #5 tck = ~tck;

   bscan_chain uut (
      .tck(tck), .rst_n(rst_n), .tdi(tdi), .cap_dr(cap_dr), .shf_dr(shf_dr),
      .upd_dr(upd_dr), .extest(extest), .core_out(core_out), .core_oe(core_oe),
      .core_bo(core_bo), .core_boe(core_boe), .pin_in(pin_in), .pin_bi(pin_bi),
      .pin_out(pin_out), .pin_oe(pin_oe), .pin_bo(pin_bo), .pin_boe(pin_boe),
      .core_in(core_in), .core_bi(core_bi), .tdo(tdo)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // pins packed as {boe1,bo1,boe0,bo0,oe1,out1,oe0,out0}
   function automatic logic [7:0] pins();
      return {pin_boe[1], pin_bo[1], pin_boe[0], pin_bo[0],
              pin_oe[1], pin_out[1], pin_oe[0], pin_out[0]};
   endfunction

   // expected pins from a 12-cell pattern (R5 positions)
   function automatic logic [7:0] pins_of(input logic [11:0] p);
      return {p[11], p[10], p[8], p[7], p[5], p[4], p[3], p[2]};
   endfunction

   task automatic step();
      @(posedge tck);
      #1;
   endtask

   task automatic shift12(input logic [11:0] din, output logic [11:0] dout);
      for (int i = 0; i < 12; i++) begin
         dout[i] = tdo;
         tdi = din[i];
         shf_dr = 1'b1;
         step();
      end
      shf_dr = 1'b0;
   endtask

   task automatic update();
      upd_dr = 1'b1;
      step();
      upd_dr = 1'b0;
   endtask

   task automatic t_reset();
      step();
      rst_n = 1'b0;
      step();
      chk(pins() == 8'hAA, "R8 safe pins", pins(), 8'hAA);
      chk(tdo == 1'b0, "R8 shift stage", tdo, 0);
      rst_n = 1'b1;
      step();
      chk(pins() == 8'hAA, "R8 after release", pins(), 8'hAA);
   endtask

   task automatic t_sample();
      logic [11:0] got, exp;
      extest = 1'b0;
      pin_in = 2'b10; core_out = 2'b01; core_oe = 2'b10;
      pin_bi = 2'b01; core_bo = 2'b10; core_boe = 2'b11;
      // cell order per R1/R2
      exp = {core_boe[1], core_bo[1], pin_bi[1], core_boe[0], core_bo[0], pin_bi[0],
             core_oe[1], core_out[1], core_oe[0], core_out[0], pin_in[1], pin_in[0]};
      cap_dr = 1'b1;
      step();
      cap_dr = 1'b0;
      shift12(12'h000, got);
      chk(got == exp, "R1 R2 capture order", got, exp);
      chk(pins() == {core_boe[1], core_bo[1], core_boe[0], core_bo[0],
                     core_oe[1], core_out[1], core_oe[0], core_out[0]},
          "R7 pass-through", pins(), 0);
      // second capture with inverted sources
      pin_in = ~pin_in; core_out = ~core_out; core_oe = ~core_oe;
      pin_bi = ~pin_bi; core_bo = ~core_bo; core_boe = ~core_boe;
      cap_dr = 1'b1;
      step();
      cap_dr = 1'b0;
      shift12(12'h000, got);
      chk(got == ~exp, "R2 inverted capture", got, ~exp);
   endtask

   task automatic t_load_apply();
      logic [11:0] p1, p2, got;
      p1 = 12'hB5A;
      extest = 1'b0;
      core_out = 2'b00; core_oe = 2'b00; core_bo = 2'b00; core_boe = 2'b00;
      shift12(p1, got);
      update();
      chk(pins() == 8'h00, "R7 latches ignored", pins(), 0);
      extest = 1'b1;
      #1;
      chk(pins() == pins_of(p1), "R5 pins from latches", pins(), pins_of(p1));
      // control zeros, data ones: pins float
      p2 = 12'b0110_1101_0111 & ~12'b1001_0010_1000;
      shift12(p2, got);
      chk(got == p1, "R3 shifted-out pattern", got, p1);
      chk(pins() == pins_of(p1), "R4 no change before update", pins(), pins_of(p1));
      update();
      chk(pins() == pins_of(p2), "R5 second pattern", pins(), pins_of(p2));
      chk(pin_oe == 2'b00 && pin_boe == 2'b00, "R6 control zero floats",
          {pin_boe, pin_oe}, 0);
      // capture does not touch the latches
      cap_dr = 1'b1;
      step();
      cap_dr = 1'b0;
      chk(pins() == pins_of(p2), "R4 capture leaves latches", pins(), pins_of(p2));
      // enables back on
      shift12(12'hFFF, got);
      update();
      chk(pin_oe == 2'b11 && pin_boe == 2'b11, "R6 control one enables",
          {pin_boe, pin_oe}, 4'hF);
      // hold: no strobes, tdo keeps its value
      step();
      step();
      chk(tdo == 1'b1, "R3 hold", tdo, 1);
      extest = 1'b0;
      core_out = 2'b10; core_oe = 2'b01; core_bo = 2'b01; core_boe = 2'b10;
      #1;
      chk(pins() == 8'h96, "R7 back to core", pins(), 8'h96);
   endtask

   task automatic t_observe();
      extest = 1'b1;
      for (int v = 0; v < 4; v++) begin
         pin_in = 2'(v);
         pin_bi = 2'(3 - v);
         #1;
         chk(core_in == 2'(v) && core_bi == 2'(3 - v), "R9 core observes pins",
             {core_bi, core_in}, {2'(3 - v), 2'(v)});
      end
   endtask

   initial begin : watchdog
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_sample();
      t_load_apply();
      t_observe();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule